// File: doc/BRIEF.md
# Intra Wavefront Macroblock Scheduler

This block decides the order in which the macroblocks of one frame go to an intra-prediction engine. A macroblock predicts from the pixels of its left, upper and upper-right neighbours, so it cannot start until those neighbours have been reconstructed. The scheduler groups the grid into diagonal waves. Wave number is column plus twice the row, which places every needed neighbour in a strictly earlier wave. It issues the members of a wave back to back, and it waits for every one of them to report completion before it opens the next wave.

Software or an upstream controller gives the picture size in pixels and pulses a start input. The scheduler rounds each dimension up to whole 16-pixel macroblocks. It then emits column, row, linear address and wave number over a valid/ready handshake. The downstream engine returns one completion pulse per finished macroblock. Between waves the block raises a one-cycle barrier marker, and it raises frame-done once the last wave has drained.

Top module: `intraWaveSched`

## Requirements
- R1: The grid is ceil(width/16) macroblocks wide and ceil(height/16) tall. Exactly that many macroblocks are issued per frame, each once.
- R2: No macroblock is issued before its left, upper and upper-right neighbours (those inside the grid) have been reported complete.
- R3: Issue order is by wave index x + 2*y ascending, and within one wave by row y ascending. Grid positions outside the picture emit nothing.
- R4: No macroblock of a wave is issued until every macroblock of the previous wave has returned its completion pulse. `issueWave` equals the number of barriers already seen in the frame.
- R5: `waveBarrier` is high for exactly one cycle after each wave drains. A frame shows mbWidth + 2*(mbHeight-1) such pulses.
- R6: `issueAddr` equals y*mbWidth + x for the issued `issueX`/`issueY`.
- R7: While `issueValid` is high and `issueReady` is low, the offered macroblock (valid, coordinates, address) is held unchanged.
- R8: `frameDone` is high when idle, falls the cycle after an accepted start with nonzero size, and rises after the final barrier. A start pulse while `frameDone` is low is ignored. `issueValid` is never high together with `frameDone`.
- R9: A start with zero width or zero height issues nothing and leaves `frameDone` high.
- R10: After reset `issueValid` and `waveBarrier` are low and `frameDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a frame (taken only while frameDone is high) |
| frameWidth | input | PIX_W | Picture width in pixels, sampled on start |
| frameHeight | input | PIX_W | Picture height in pixels, sampled on start |
| issueValid | output | 1 | A macroblock is offered |
| issueReady | input | 1 | Engine accepts the offered macroblock |
| issueX | output | MB_W | Macroblock column |
| issueY | output | MB_W | Macroblock row |
| issueAddr | output | ADDR_W | Linear macroblock address |
| issueWave | output | WAVE_W | Wave index of the offered macroblock |
| doneValid | input | 1 | One macroblock finished prediction |
| waveBarrier | output | 1 | One-cycle marker: the current wave fully drained |
| frameDone | output | 1 | Idle / frame complete |

## Verification
The main function runs on grid shapes that stress different parts of the wave walk. A square-ish small grid has several members in each mid wave. A single-row and a single-column grid produce degenerate waves, and the column case skips every odd wave position. Widths and heights that are not multiples of 16 check the rounding, and a full 1080p grid exercises long scans that mostly skip off-grid positions. For every frame a reference order computed in the bench is compared with the issued stream. A scoreboard of completed macroblocks catches any dependency violation, and a slow, bursty completion pattern with periodic ready stalls shows whether barriers truly wait for the drain. Directed cases cover zero dimensions and a start pulse during a busy frame.

// File: rtl/intraWavePkg.sv
package intraWavePkg;
  typedef struct packed {
    logic load;
    logic stepY;
    logic nextWave;
    logic fire;
  } waveStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN
  } waveState_e;
endpackage

// File: rtl/waveDatapath.sv
module waveDatapath
  import intraWavePkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int MB_W   = PIX_W - 3,
  parameter int ADDR_W = 2 * MB_W,
  parameter int WAVE_W = MB_W + 2,
  parameter int CNT_W  = MB_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  waveStrobe_t       strb,
  input  logic [PIX_W-1:0]  frameWidth,
  input  logic [PIX_W-1:0]  frameHeight,
  input  logic              doneValid,
  output logic              dimZero,
  output logic              candOk,
  output logic              lastInWave,
  output logic              lastWave,
  output logic              countZero,
  output logic [MB_W-1:0]   curX,
  output logic [MB_W-1:0]   curY,
  output logic [ADDR_W-1:0] curAddr,
  output logic [WAVE_W-1:0] curWave
);
  logic [MB_W-1:0]   mbW, mbH;
  logic [WAVE_W-1:0] wave;
  logic [MB_W-1:0]   yPos;
  logic [CNT_W-1:0]  outstanding;

  logic [PIX_W:0]    wSum, hSum;
  logic [WAVE_W-1:0] twoY, xVal, waveLimit;
  logic [MB_W:0]     yNext;
  logic              xNeg, doDec;

  // Round pixel size up to whole macroblocks.
  assign wSum    = {1'b0, frameWidth}  + (PIX_W+1)'(15);
  assign hSum    = {1'b0, frameHeight} + (PIX_W+1)'(15);
  assign dimZero = (frameWidth == '0) || (frameHeight == '0);

  // Column belonging to the current (wave, row) candidate.
  assign twoY   = {1'b0, yPos, 1'b0};
  assign xNeg   = twoY > wave;
  assign xVal   = wave - twoY;
  assign candOk = !xNeg && (xVal < {2'b0, mbW}) && (yPos < mbH);

  assign yNext      = {1'b0, yPos} + (MB_W+1)'(1);
  assign lastInWave = (yNext >= {1'b0, mbH}) || ({yNext, 1'b0} > wave);

  assign waveLimit = {2'b0, mbW} + {1'b0, mbH, 1'b0} - WAVE_W'(3);
  assign lastWave  = wave == waveLimit;
  assign countZero = outstanding == '0;

  assign curX    = xVal[MB_W-1:0];
  assign curY    = yPos;
  assign curWave = wave;
  assign curAddr = ADDR_W'(yPos) * ADDR_W'(mbW) + ADDR_W'(curX);

  assign doDec = doneValid && !countZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mbW  <= '0;
      mbH  <= '0;
      wave <= '0;
      yPos <= '0;
    end else if (strb.load) begin
      mbW  <= wSum[PIX_W:4];
      mbH  <= hSum[PIX_W:4];
      wave <= '0;
      yPos <= '0;
    end else if (strb.nextWave) begin
      wave <= wave + WAVE_W'(1);
      yPos <= '0;
    end else if (strb.stepY) begin
      yPos <= yPos + MB_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.load) begin
      outstanding <= '0;
    end else begin
      case ({strb.fire, doDec})
        2'b10:   outstanding <= outstanding + CNT_W'(1);
        2'b01:   outstanding <= outstanding - CNT_W'(1);
        default: outstanding <= outstanding;
      endcase
    end
  end
endmodule

// File: rtl/waveCtrl.sv
module waveCtrl
  import intraWavePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        issueReady,
  input  logic        dimZero,
  input  logic        candOk,
  input  logic        lastInWave,
  input  logic        lastWave,
  input  logic        countZero,
  output waveStrobe_t strb,
  output logic        issueValid,
  output logic        waveBarrier,
  output logic        frameDone
);
  waveState_e state, nxt;

  always_comb begin
    strb        = '0;
    issueValid  = 1'b0;
    waveBarrier = 1'b0;
    nxt         = state;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.load = 1'b1;
          if (!dimZero) nxt = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        issueValid = candOk;
        if (!candOk || issueReady) begin
          strb.fire = candOk;
          if (lastInWave) nxt = ST_DRAIN;
          else            strb.stepY = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (countZero) begin
          waveBarrier = 1'b1;
          if (lastWave) begin
            nxt = ST_IDLE;
          end else begin
            strb.nextWave = 1'b1;
            nxt = ST_ISSUE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign frameDone = state == ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/intraWaveSched.sv
module intraWaveSched
  import intraWavePkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int MB_W   = PIX_W - 3,
  parameter int ADDR_W = 2 * MB_W,
  parameter int WAVE_W = MB_W + 2,
  parameter int CNT_W  = MB_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [PIX_W-1:0]  frameWidth,
  input  logic [PIX_W-1:0]  frameHeight,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [MB_W-1:0]   issueX,
  output logic [MB_W-1:0]   issueY,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [WAVE_W-1:0] issueWave,
  input  logic              doneValid,
  output logic              waveBarrier,
  output logic              frameDone
);
  waveStrobe_t strb;
  logic dimZero, candOk, lastInWave, lastWave, countZero;

  waveCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .issueReady (issueReady),
    .dimZero    (dimZero),
    .candOk     (candOk),
    .lastInWave (lastInWave),
    .lastWave   (lastWave),
    .countZero  (countZero),
    .strb       (strb),
    .issueValid (issueValid),
    .waveBarrier(waveBarrier),
    .frameDone  (frameDone)
  );

  waveDatapath #(
    .PIX_W (PIX_W),
    .MB_W  (MB_W),
    .ADDR_W(ADDR_W),
    .WAVE_W(WAVE_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .frameWidth (frameWidth),
    .frameHeight(frameHeight),
    .doneValid  (doneValid),
    .dimZero    (dimZero),
    .candOk     (candOk),
    .lastInWave (lastInWave),
    .lastWave   (lastWave),
    .countZero  (countZero),
    .curX       (issueX),
    .curY       (issueY),
    .curAddr    (issueAddr),
    .curWave    (issueWave)
  );
endmodule

// File: rtl/intraWaveSchedChk.sv
module intraWaveSchedChk #(
  parameter int PIX_W  = 13,
  parameter int MB_W   = PIX_W - 3,
  parameter int ADDR_W = 2 * MB_W,
  parameter int CNT_W  = MB_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [PIX_W-1:0]  frameWidth,
  input logic [PIX_W-1:0]  frameHeight,
  input logic              issueValid,
  input logic              issueReady,
  input logic [MB_W-1:0]   issueX,
  input logic [MB_W-1:0]   issueY,
  input logic [ADDR_W-1:0] issueAddr,
  input logic              doneValid,
  input logic              waveBarrier,
  input logic              frameDone
);
  // Outstanding work seen at the ports only.
  logic [CNT_W-1:0] seenOut;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenOut <= '0;
    end else begin
      case ({issueValid && issueReady, doneValid && seenOut != '0})
        2'b10:   seenOut <= seenOut + CNT_W'(1);
        2'b01:   seenOut <= seenOut - CNT_W'(1);
        default: seenOut <= seenOut;
      endcase
    end
  end

  // R4
  drain_before_barrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    waveBarrier |-> seenOut == '0);

  // R5
  barrier_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    waveBarrier |=> !waveBarrier);

  // R7
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady |=> issueValid && $stable(issueAddr)
                                  && $stable(issueX) && $stable(issueY));

  // R8
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !frameDone);

  // R9
  zero_dim_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && startPulse && (frameWidth == '0 || frameHeight == '0) |=> frameDone);
endmodule

bind intraWaveSched intraWaveSchedChk #(
  .PIX_W (PIX_W),
  .MB_W  (MB_W),
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .frameWidth (frameWidth),
  .frameHeight(frameHeight),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .issueX     (issueX),
  .issueY     (issueY),
  .issueAddr  (issueAddr),
  .doneValid  (doneValid),
  .waveBarrier(waveBarrier),
  .frameDone  (frameDone)
);

// File: tb/intraWaveSched_tb.sv
module intraWaveSched_tb;
  localparam int PIX_W  = 13;
  localparam int MB_W   = PIX_W - 3;
  localparam int ADDR_W = 2 * MB_W;
  localparam int WAVE_W = MB_W + 2;

  // {width, height, expected macroblocks, expected waves}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{64,   48,   12,   8},
    '{17,   1,    2,    2},
    '{1,    100,  7,    13},
    '{50,   33,   12,   8},
    '{16,   16,   1,    1},
    '{1920, 1080, 8160, 254}
  };

  logic clk = 0;
  logic rstN = 0;
  logic startPulse = 0;
  logic [PIX_W-1:0] frameWidth = '0, frameHeight = '0;
  logic issueValid, issueReady, doneValid, waveBarrier, frameDone;
  logic [MB_W-1:0] issueX, issueY;
  logic [ADDR_W-1:0] issueAddr;
  logic [WAVE_W-1:0] issueWave;

  always #5 clk = ~clk;

  intraWaveSched u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .frameWidth(frameWidth), .frameHeight(frameHeight),
    .issueValid(issueValid), .issueReady(issueReady),
    .issueX(issueX), .issueY(issueY), .issueAddr(issueAddr), .issueWave(issueWave),
    .doneValid(doneValid), .waveBarrier(waveBarrier), .frameDone(frameDone)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int mbWB = 1;
  int issues, barriers, orderErr, depErr, drainErr, waveErr, addrErr, holdErr, pulseErr;
  int expQ[$];
  int pendQ[$];
  bit doneMap [0:8191];
  bit stallPrev = 0, barPrev = 0;
  logic [ADDR_W-1:0] savAddr;
  logic [MB_W-1:0] savX, savY;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, completion model and ready pattern, all at the falling edge.
  always @(negedge clk) begin
    if (!rstN) begin
      doneValid  = 0;
      issueReady = 0;
    end else begin
      cyc++;
      if (stallPrev && !(issueValid && issueAddr == savAddr && issueX == savX && issueY == savY))
        holdErr++;
      if (waveBarrier) begin
        if (barPrev) pulseErr++;
        if (pendQ.size() != 0) drainErr++;
        barriers++;
      end
      barPrev = waveBarrier;
      if (pendQ.size() > 0 && (cyc % 3) != 1) begin
        int a;
        a = pendQ.pop_front();
        doneMap[a] = 1;
        doneValid = 1;
      end else begin
        doneValid = 0;
      end
      issueReady = (cyc % 5) != 2;
      if (issueValid && issueReady) begin
        int x, y, a;
        x = int'(issueX);
        y = int'(issueY);
        a = int'(issueAddr);
        issues++;
        if (expQ.size() == 0) orderErr++;
        else if (expQ.pop_front() != a) orderErr++;
        if (int'(issueWave) != barriers) waveErr++;
        if (a != y * mbWB + x) addrErr++;
        if (y > 0 && !doneMap[y*mbWB - mbWB + x]) depErr++;
        if (y > 0 && x + 1 < mbWB && !doneMap[y*mbWB - mbWB + x + 1]) depErr++;
        if (x > 0 && !doneMap[y*mbWB + x - 1]) depErr++;
        pendQ.push_back(a);
      end
      stallPrev = issueValid && !issueReady;
      savAddr = issueAddr;
      savX = issueX;
      savY = issueY;
    end
  end

  task automatic runFrame(input int w, input int h, input int expMbs, input int expWaves,
                          input bit poke);
    int mbHB, nWaves, n;
    mbWB = (w + 15) / 16;
    mbHB = (h + 15) / 16;
    nWaves = mbWB + 2 * (mbHB - 1);
    expQ.delete();
    for (int wv = 0; wv < nWaves; wv++)
      for (int y = 0; y < mbHB; y++)
        if (wv - 2*y >= 0 && wv - 2*y < mbWB) expQ.push_back(y * mbWB + wv - 2*y);
    for (int i = 0; i < 8192; i++) doneMap[i] = 0;
    issues = 0; barriers = 0; orderErr = 0; depErr = 0; drainErr = 0;
    waveErr = 0; addrErr = 0; holdErr = 0; pulseErr = 0;
    @(negedge clk);
    frameWidth = PIX_W'(w);
    frameHeight = PIX_W'(h);
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    check(frameDone == 0, "R8 frameDone falls after start", int'(frameDone), 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      frameWidth = PIX_W'(16);
      frameHeight = PIX_W'(16);
      startPulse = 1;
      @(negedge clk);
      startPulse = 0;
    end
    n = 0;
    while (!frameDone && n < 100000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(frameDone == 1, "R8 frameDone after last wave", int'(frameDone), 1);
    check(issues == expMbs, "R1 macroblock count", issues, expMbs);
    check(orderErr == 0, "R3 wave/row issue order", orderErr, 0);
    check(depErr == 0, "R2 neighbour dependencies", depErr, 0);
    check(drainErr == 0 && waveErr == 0, "R4 drain barrier", drainErr + waveErr, 0);
    check(barriers == expWaves, "R5 barrier count", barriers, expWaves);
    check(pulseErr == 0, "R5 single-cycle barrier", pulseErr, 0);
    check(addrErr == 0, "R6 linear address", addrErr, 0);
    check(holdErr == 0, "R7 hold under stall", holdErr, 0);
  endtask

  task automatic zeroDim(input int w, input int h);
    int lowSeen;
    issues = 0;
    lowSeen = 0;
    @(negedge clk);
    frameWidth = PIX_W'(w);
    frameHeight = PIX_W'(h);
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    for (int i = 0; i < 20; i++) begin
      if (!frameDone || issueValid) lowSeen++;
      @(negedge clk);
    end
    check(issues == 0, "R9 zero size issues nothing", issues, 0);
    check(lowSeen == 0, "R9 zero size keeps frameDone", lowSeen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10
    check(issueValid == 0, "R10 reset issueValid", int'(issueValid), 0);
    check(waveBarrier == 0, "R10 reset waveBarrier", int'(waveBarrier), 0);
    check(frameDone == 1, "R10 reset frameDone", int'(frameDone), 1);

    for (int v = 0; v < NVEC; v++)
      runFrame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);

    zeroDim(0, 40);
    zeroDim(40, 0);
    // R8: a second start during a busy frame leaves it untouched
    runFrame(64, 48, 12, 8, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule